// File: doc/BRIEF.md
# Program-Sequenced Mesh Operand Switch

This block is the routing switch that sits beside the processor in one tile of a two-dimensional mesh. It has five word ports. One faces the local processor and the other four face the north, south, east and west neighbour tiles. Each port has an input side and an output side with valid/ready flow control. Routing does not come from packet headers. A small program counter inside the switch steps through a local route memory, and every route word names the source that feeds each output for that step. One step can therefore set up several independent connections at the same time, for example processor to east while north goes to south. It can also copy one source to several outputs.

A step is all-or-nothing. Every source it names must hold valid data and every destination it names must be ready before any word moves. While that is not the case, the switch waits on the step and the counter does not move. Because each source is consumed at most once per step, and steps run in program order, the words from any one source leave in the order they arrived. The route memory is written through a load port while the switch is held in reset. Execution begins at entry 0 when reset is released, and the counter wraps after the last entry, so a compiled schedule loops.

Top module: `static_route_switch`

## Requirements
- R1: While rst_n is low, out_valid, in_ready and err_o are all 0, whatever the inputs are.
- R2: The load port writes route entry ld_addr only while rst_n is low. A write attempted while rst_n is high leaves the memory unchanged.
- R3: After reset the program counter starts at entry 0. It moves up by one on every step that completes or is rejected, and it wraps from entry DEPTH-1 back to entry 0.
- R4: A route word holds one 3-bit source selector per output. Output k uses bits [3k+2:3k]. Both ports and selector values are ordered P, N, S, E, W: ports are indices 0 to 4, and selector values are 1 to 5. Selector 0 leaves that output idle.
- R5: A step completes only in a cycle where every named source has in_valid high and every named destination has out_ready high. Otherwise no out_valid or in_ready is raised and the program counter holds. Downstream ready must not depend on out_valid.
- R6: A source named by several outputs raises in_ready once, in the same cycle that all of its destinations raise out_valid.
- R7: In a completing step, each active output carries the word on the input its selector names.
- R8: A selector value of 6 or 7 marks the route word as illegal. err_o is high for that cycle, no port transfers, and the counter moves past the word.
- R9: In a completing step, in_ready is high only for named sources and out_valid is high only for named destinations.
- R10: A route word whose selectors are all 0 completes at once, whatever the port handshakes are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; also enables memory loading |
| ld_we | input | 1 | Route memory write strobe |
| ld_addr | input | AW | Route memory write address |
| ld_word | input | 15 | Route word to write |
| in_data | input | 5*DW | Input words, port k in bits [DW*k+DW-1:DW*k] |
| in_valid | input | 5 | Input word present, one bit per port |
| in_ready | output | 5 | Input word consumed this cycle |
| out_data | output | 5*DW | Output words, same packing as in_data |
| out_valid | output | 5 | Output word delivered this cycle |
| out_ready | input | 5 | Neighbour can accept a word |
| err_o | output | 1 | Current route word is illegal and is being skipped |

## Verification
Some properties are checked on every cycle. All outputs stay quiet in reset. No output fires into a busy neighbour. No input is consumed without valid data. A delivery always consumes at least one input. An illegal word moves no data and still moves the counter on. Other behaviour depends on the contents of the program and can only be shown by the bench scenarios: the selector encoding, which input feeds which output, multicast, wrap after the last entry, and whether a load outside reset is ignored. For those, a behavioural model of the counter and the route memory predicts each port every cycle, using both directed stalls and randomly varied handshakes.

// File: rtl/swx_pkg.sv
package swx_pkg;
   localparam int NP      = 5;
   localparam int SELW    = 3;
   localparam int INSTR_W = NP * SELW;
   localparam int MAX_SEL = NP;

   typedef logic [SELW-1:0] sel_t;

   // selector codes: 0 idle, then P, N, S, E, W
   typedef enum logic [SELW-1:0] {
      SRC_NONE  = 3'd0,
      SRC_PROC  = 3'd1,
      SRC_NORTH = 3'd2,
      SRC_SOUTH = 3'd3,
      SRC_EAST  = 3'd4,
      SRC_WEST  = 3'd5
   } src_code_e;
endpackage

// File: rtl/swx_imem.sv
module swx_imem #(
   parameter int DEPTH = 64,
   parameter int WIDTH = 15,
   localparam int AW = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             we,
   input  logic [AW-1:0]    waddr,
   input  logic [WIDTH-1:0] wdata,
   input  logic [AW-1:0]    raddr,
   output logic [WIDTH-1:0] rdata
);
   logic [WIDTH-1:0] store [DEPTH];

   always_ff @(posedge clk) begin
      if (we) store[waddr] <= wdata;
   end

   assign rdata = store[raddr];
endmodule

// File: rtl/swx_pc.sv
module swx_pc #(
   parameter int DEPTH = 64,
   localparam int AW = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          advance,
   output logic [AW-1:0] pc
);
   localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
         always_ff @(posedge clk) begin
            if (!rst_n)       pc <= '0;
            else if (advance) pc <= pc + 1'b1;
         end
      end else begin : g_any
         always_ff @(posedge clk) begin
            if (!rst_n)       pc <= '0;
            else if (advance) pc <= (pc == LAST) ? '0 : pc + 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/swx_route_ctrl.sv
module swx_route_ctrl
   import swx_pkg::*;
(
   input  logic               en,
   input  logic [INSTR_W-1:0] instr,
   input  logic [NP-1:0]      in_valid,
   input  logic [NP-1:0]      out_ready,
   output logic               fire,
   output logic               illegal,
   output logic [NP-1:0]      src_used,
   output logic [NP-1:0]      dst_used
);
   logic bad;

   always_comb begin
      src_used = '0;
      dst_used = '0;
      bad      = 1'b0;
      for (int o = 0; o < NP; o++) begin
         sel_t s;
         s = instr[o*SELW +: SELW];
         if (s != SRC_NONE) begin
            if (s > SELW'(MAX_SEL)) begin
               bad = 1'b1;
            end else begin
               dst_used[o]            = 1'b1;
               src_used[s - 3'd1]     = 1'b1;
            end
         end
      end
   end

   assign illegal = en & bad;
   assign fire    = en & ~bad
                  & ((src_used & ~in_valid) == '0)
                  & ((dst_used & ~out_ready) == '0);
endmodule

// File: rtl/swx_xbar.sv
module swx_xbar
   import swx_pkg::*;
#(
   parameter int DW = 32
) (
   input  logic [INSTR_W-1:0] instr,
   input  logic [NP*DW-1:0]   in_data,
   output logic [NP*DW-1:0]   out_data
);
   genvar o;
   generate
      for (o = 0; o < NP; o++) begin : g_out
         sel_t          s;
         logic [DW-1:0] pick;
         assign s = instr[o*SELW +: SELW];
         always_comb begin
            pick = '0;
            for (int i = 0; i < NP; i++) begin
               if (s == SELW'(i + 1)) pick = in_data[i*DW +: DW];
            end
         end
         assign out_data[o*DW +: DW] = pick;
      end
   endgenerate
endmodule

// File: rtl/static_route_switch.sv
module static_route_switch
   import swx_pkg::*;
#(
   parameter int DW    = 32,
   parameter int DEPTH = 64,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ld_we,
   input  logic [AW-1:0]      ld_addr,
   input  logic [INSTR_W-1:0] ld_word,
   input  logic [NP*DW-1:0]   in_data,
   input  logic [NP-1:0]      in_valid,
   output logic [NP-1:0]      in_ready,
   output logic [NP*DW-1:0]   out_data,
   output logic [NP-1:0]      out_valid,
   input  logic [NP-1:0]      out_ready,
   output logic               err_o
);
   generate
      if (DW < 1) begin : g_bad_dw
         $error("DW must be at least 1");
      end
      if (DEPTH < 2) begin : g_bad_depth
         $error("DEPTH must be at least 2");
      end
   endgenerate

   logic [AW-1:0]      pc;
   logic [INSTR_W-1:0] instr;
   logic               fire;
   logic               illegal;
   logic [NP-1:0]      src_used;
   logic [NP-1:0]      dst_used;

   swx_imem #(.DEPTH(DEPTH), .WIDTH(INSTR_W)) u_imem (
      .clk   (clk),
      .we    (ld_we & ~rst_n),
      .waddr (ld_addr),
      .wdata (ld_word),
      .raddr (pc),
      .rdata (instr)
   );

   swx_pc #(.DEPTH(DEPTH)) u_pc (
      .clk     (clk),
      .rst_n   (rst_n),
      .advance (fire | illegal),
      .pc      (pc)
   );

   swx_route_ctrl u_ctrl (
      .en        (rst_n),
      .instr     (instr),
      .in_valid  (in_valid),
      .out_ready (out_ready),
      .fire      (fire),
      .illegal   (illegal),
      .src_used  (src_used),
      .dst_used  (dst_used)
   );

   swx_xbar #(.DW(DW)) u_xbar (
      .instr    (instr),
      .in_data  (in_data),
      .out_data (out_data)
   );

   assign in_ready  = fire ? src_used : '0;
   assign out_valid = fire ? dst_used : '0;
   assign err_o     = illegal;
endmodule

// File: rtl/static_route_switch_chk.sv
module static_route_switch_chk
   import swx_pkg::*;
#(
   parameter int AW = 6
) (
   input logic          clk,
   input logic          rst_n,
   input logic [NP-1:0] in_valid,
   input logic [NP-1:0] in_ready,
   input logic [NP-1:0] out_valid,
   input logic [NP-1:0] out_ready,
   input logic          err_o,
   input logic [AW-1:0] pc
);
   // R1: quiet while reset is held
   assert_quiet_in_reset_R1: assert property (@(posedge clk)
      !rst_n |-> (out_valid == '0 && in_ready == '0 && !err_o));

   // R5: never deliver into a port that is not ready
   assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid & ~out_ready) == '0);

   // R9: never consume an input that holds no word
   assert_no_underflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (in_ready & ~in_valid) == '0);

   // R6: every delivery consumes a source in the same cycle
   assert_delivery_consumes_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid != '0) |-> (in_ready != '0));

   // R8: an illegal word moves no data
   assert_illegal_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> (out_valid == '0 && in_ready == '0));

   // R8: an illegal word is skipped
   assert_illegal_skipped_R8: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |=> (pc != $past(pc)));
endmodule

bind static_route_switch static_route_switch_chk #(.AW(AW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_ready  (in_ready),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .err_o     (err_o),
   .pc        (pc)
);

// File: tb/static_route_switch_test.sv
`timescale 1ns/1ps
module static_route_switch_test;
   localparam int DW    = 32;
   localparam int DEPTH = 64;
   localparam int AW    = 6;
   localparam int NP    = 5;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              ld_we = 1'b0;
   logic [AW-1:0]     ld_addr = '0;
   logic [14:0]       ld_word = '0;
   logic [NP*DW-1:0]  in_data = '0;
   logic [NP-1:0]     in_valid = '0;
   logic [NP-1:0]     in_ready;
   logic [NP*DW-1:0]  out_data;
   logic [NP-1:0]     out_valid;
   logic [NP-1:0]     out_ready = '0;
   logic              err_o;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   logic [14:0] prog [DEPTH];
   int mpc = 0;

   always #4 clk = ~clk;

   static_route_switch #(.DW(DW), .DEPTH(DEPTH)) uut (
      .clk(clk), .rst_n(rst_n), .ld_we(ld_we), .ld_addr(ld_addr), .ld_word(ld_word),
      .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
      .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready), .err_o(err_o)
   );

   // selectors per output, ordered P, N, S, E, W
   function automatic logic [14:0] enc(int p, int n, int s, int e, int w);
      return {3'(w), 3'(e), 3'(s), 3'(n), 3'(p)};
   endfunction

   task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h (pc model %0d)", tag, act, exp, mpc);
      end
   endtask

   // one clock: inputs are already driven at posedge+1; check at posedge+3
   task automatic step(string tag);
      logic [NP-1:0] srcm, dstm, ev, er;
      bit illegal, fire;
      #2;
      srcm = '0; dstm = '0; illegal = 0;
      for (int o = 0; o < NP; o++) begin
         int s;
         s = int'(prog[mpc][o*3 +: 3]);
         if (s > 5) illegal = 1;
         else if (s != 0) begin dstm[o] = 1'b1; srcm[s-1] = 1'b1; end
      end
      fire = !illegal && ((srcm & ~in_valid) == 0) && ((dstm & ~out_ready) == 0);
      ev = fire ? dstm : '0;
      er = fire ? srcm : '0;
      check(tag, DW'(out_valid), DW'(ev));
      check("R6", DW'(in_ready), DW'(er));
      check("R8", DW'(err_o), DW'(illegal));
      for (int o = 0; o < NP; o++) begin
         if (ev[o]) begin
            int s;
            s = int'(prog[mpc][o*3 +: 3]);
            check("R7", out_data[o*DW +: DW], in_data[(s-1)*DW +: DW]);
         end
      end
      if (fire || illegal) mpc = (mpc + 1) % DEPTH;
      @(posedge clk); #1;
   endtask

   task automatic randomize_data();
      for (int i = 0; i < NP; i++) in_data[i*DW +: DW] = $urandom;
   endtask

   initial begin
      for (int i = 0; i < DEPTH; i++) prog[i] = '0;
      prog[0] = enc(0, 0, 2, 1, 0);   // P->E and N->S
      prog[1] = enc(5, 0, 0, 0, 0);   // W->P
      prog[2] = enc(0, 0, 0, 2, 2);   // N->E and N->W
      prog[4] = enc(0, 6, 0, 0, 0);   // illegal selector

      @(posedge clk); #1;
      in_valid = '1; out_ready = '1; randomize_data();
      for (int i = 0; i < DEPTH; i++) begin
         ld_we = 1'b1; ld_addr = AW'(i); ld_word = prog[i];
         #2;
         check("R1", DW'({out_valid, in_ready, err_o}), '0);
         @(posedge clk); #1;
      end
      ld_we = 1'b0;
      rst_n = 1'b1;
      mpc = 0;

      // entry 0 with a late load attempt (must be ignored)
      ld_we = 1'b1; ld_addr = '0; ld_word = 15'h7fff;
      in_valid = 5'b00001; out_ready = '1; randomize_data();
      step("R5");
      ld_we = 1'b0;
      in_valid = 5'b00011; out_ready = 5'b10111;
      step("R5");
      out_ready = '1;
      step("R4");
      // entry 1: W->P
      out_ready = 5'b11110; in_valid = '1;
      step("R5");
      out_ready = '1; randomize_data();
      step("R9");
      // entry 2: multicast N
      out_ready = 5'b01111;
      step("R6");
      out_ready = '1;
      step("R6");
      // entry 3: all idle
      in_valid = '0; out_ready = '0;
      step("R10");
      // entry 4: illegal
      in_valid = '1; out_ready = '1;
      step("R8");
      // idle entries up to the wrap
      for (int i = 5; i < DEPTH; i++) step("R3");
      randomize_data();
      step("R2");
      // varied handshakes over several wraps
      for (int i = 0; i < 400; i++) begin
         in_valid  = NP'($urandom);
         out_ready = NP'($urandom);
         randomize_data();
         step("R3");
      end
      if (!done) begin
         done = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      #(8 * 20000);
      if (!done) begin
         done = 1'b1;
         total++; bad++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule